// File: doc/BRIEF.md
# Cell Header Check-Byte Generator and Checker

This block produces the eight-bit error-control byte that protects the four leading bytes of a fixed-length cell header. The header may arrive one byte per clock, most significant byte first, or all at once as a 32-bit word in a single cycle. The block keeps a running CRC-8 remainder, using the generator x^8+x^2+x+1 and a zero start value. It then XORs the final remainder with the constant 0x55 to form the check byte.

On transmit, the result is placed in the fifth header byte, directly after the four bytes it covers. On receive, the incoming fifth byte is applied to the expected-byte input. A match flag then reports whether it equals the locally computed value. Single-bit correction, cell boundary hunting and payload scrambling belong to other blocks.

Top module: `cell_hdr_hec`

## Requirements
- R1: While reset is low at a clock edge, the block clears its state. After that edge `done_o` and `match_o` are 0.
- R2: An all-zero header yields `hec_o` = 0x55, in both byte mode and word mode.
- R3: The check byte is the CRC-8 of the header bits, taken most significant bit of the first byte first. The CRC uses feedback constant 0x07 applied when the outgoing top bit is 1, starts from 0x00, and is XORed with 0x55 at the end. For example, header 00 00 00 01 yields 0x52.
- R4: `done_o` is 0 until the fourth byte of a header is accepted. It is 1 starting with the cycle after the clock edge that accepts that byte.
- R5: Cycles with `byte_vld_i` low leave the header in progress untouched, so gaps between bytes do not change the result.
- R6: `start_i` discards any partial header and restarts the remainder at 0x00 and the byte count at zero. A byte presented in the same cycle as `start_i` is taken as the first byte of the new header.
- R7: Once a header is complete, further bytes are ignored until the next `start_i` or word load. `done_o` stays 1 and `hec_o` stays unchanged.
- R8: `word_vld_i` loads a whole header from `word_i`, with bits 31:24 treated as the first byte. It takes priority over `start_i` and the byte inputs, and replaces any partial header. `done_o` is 1 in the next cycle, and the result equals the byte-serial result for the same four bytes.
- R9: `match_o` is 1 exactly when `done_o` is 1 and `hec_o` equals `exp_hec_i`. It is 0 whenever `done_o` is 0.
- R10: `start_i` without a byte or word load drives `done_o` to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a new header (clears remainder and count) |
| byte_vld_i | input | 1 | `byte_i` carries a header byte this cycle |
| byte_i | input | 8 | Header byte, first byte first |
| word_vld_i | input | 1 | Load a whole header from `word_i` this cycle |
| word_i | input | 32 | Whole header, first byte in bits 31:24 |
| exp_hec_i | input | 8 | Received check byte to compare against |
| hec_o | output | 8 | Computed check byte, valid while `done_o` is 1 |
| done_o | output | 1 | A complete header has been processed |
| match_o | output | 1 | `done_o` and `hec_o` equals `exp_hec_i` |

## Verification
The bench builds the block with its default parameters: four header bytes of eight bits, feedback constant 0x07 and coset 0x55. This is the configuration in which the known headers, all zeros giving 0x55 and 00 00 00 01 giving 0x52, pin down the arithmetic. With four bytes, a restart after two bytes, a restart that carries a byte, and surplus bytes after completion each land on distinct count values. The 32-bit word path is cross-checked against the byte path on the same headers, and both are compared with a bit-serial reference computed in the bench.

// File: rtl/cell_hec_pkg.sv
// Shared types and constants for the cell header check-byte block.
// Assumes an eight-bit check byte; the header length is a module parameter.
package cell_hec_pkg;
    localparam int HEC_W = 8;
    typedef logic [HEC_W-1:0] hec_t;
endpackage

// File: rtl/hec_byte_step.sv
// One header byte folded into a CRC remainder: XOR the byte in, then
// shift W times, applying POLY whenever the outgoing top bit is 1.
// Purely combinational; assumes data and remainder share width W.
module hec_byte_step #(
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] rem_o
);
    logic [W-1:0] stage [W+1];

    // Seed the shift chain with the byte XORed into the remainder.
    assign stage[0] = rem_i ^ data_i;

    for (genvar b = 0; b < W; b++) begin : g_shift
        // One shift of the division, with conditional feedback.
        assign stage[b+1] = stage[b][W-1] ? ((stage[b] << 1) ^ POLY)
                                          : (stage[b] << 1);
    end

    assign rem_o = stage[W];
endmodule

// File: rtl/hec_word_fold.sv
// Whole-header remainder in one cycle: a chain of NB byte steps starting
// from zero, first byte taken from the top of the word.
// Combinational; assumes the word is exactly NB*W bits wide.
module hec_word_fold #(
    parameter int          NB   = 4,
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = 8'h07,
    localparam int         WW   = NB * W
) (
    input  logic [WW-1:0] word_i,
    output logic [W-1:0]  rem_o
);
    logic [W-1:0] chain [NB+1];

    // Every header starts from a cleared remainder.
    assign chain[0] = '0;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        hec_byte_step #(.W(W), .POLY(POLY)) u_step (
            .rem_i  (chain[g]),
            .data_i (word_i[(NB-g)*W-1 -: W]),
            .rem_o  (chain[g+1])
        );
    end

    assign rem_o = chain[NB];
endmodule

// File: rtl/hec_seq_ctrl.sv
// Holds the running remainder, byte count and completion flag.
// Word load beats start, start beats the stored state; bytes past the
// last header byte are dropped. Assumes synchronous active-low reset.
module hec_seq_ctrl #(
    parameter int  NB    = 4,
    parameter int  W     = 8,
    localparam int CNT_W = $clog2(NB + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         byte_vld_i,
    input  logic         word_vld_i,
    input  logic [W-1:0] word_rem_i,
    input  logic [W-1:0] step_rem_i,
    output logic [W-1:0] base_rem_o,
    output logic [W-1:0] rem_o,
    output logic         done_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NB);

    logic [CNT_W-1:0] cnt_q, base_cnt, cnt_nxt;
    logic [W-1:0]     rem_q, rem_nxt;
    logic             done_q, take;

    // Pick the starting point of this cycle: cleared on start, else held.
    always_comb begin
        base_rem_o = start_i ? '0 : rem_q;
        base_cnt   = start_i ? '0 : cnt_q;
        take       = byte_vld_i && (base_cnt < LAST);
        rem_nxt    = take ? step_rem_i : base_rem_o;
        cnt_nxt    = base_cnt + CNT_W'(take);
    end

    // State update with word load taking priority over the byte path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (word_vld_i) begin
            rem_q  <= word_rem_i;
            cnt_q  <= LAST;
            done_q <= 1'b1;
        end else begin
            rem_q  <= rem_nxt;
            cnt_q  <= cnt_nxt;
            done_q <= (cnt_nxt == LAST);
        end
    end

    assign rem_o  = rem_q;
    assign done_o = done_q;
endmodule

// File: rtl/cell_hdr_hec.sv
// Top level: check-byte generator/checker for a cell header.
// Byte-serial or single-cycle word entry; result is the CRC remainder
// XORed with COSET. The match flag compares against a received byte
// and is qualified by done. Assumes synchronous active-low reset.
module cell_hdr_hec
    import cell_hec_pkg::*;
#(
    parameter int   HDR_BYTES = 4,
    parameter hec_t POLY      = 8'h07,
    parameter hec_t COSET     = 8'h55,
    localparam int  WORD_W    = HDR_BYTES * HEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_vld_i,
    input  logic [HEC_W-1:0]  byte_i,
    input  logic              word_vld_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [HEC_W-1:0]  exp_hec_i,
    output logic [HEC_W-1:0]  hec_o,
    output logic              done_o,
    output logic              match_o
);
    hec_t base_rem, step_rem, word_rem, rem_q;

    hec_byte_step #(.W(HEC_W), .POLY(POLY)) u_step (
        .rem_i  (base_rem),
        .data_i (byte_i),
        .rem_o  (step_rem)
    );

    hec_word_fold #(.NB(HDR_BYTES), .W(HEC_W), .POLY(POLY)) u_fold (
        .word_i (word_i),
        .rem_o  (word_rem)
    );

    hec_seq_ctrl #(.NB(HDR_BYTES), .W(HEC_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .byte_vld_i (byte_vld_i),
        .word_vld_i (word_vld_i),
        .word_rem_i (word_rem),
        .step_rem_i (step_rem),
        .base_rem_o (base_rem),
        .rem_o      (rem_q),
        .done_o     (done_o)
    );

    // Apply the coset and qualify the comparison with completion.
    always_comb begin
        hec_o   = rem_q ^ COSET;
        match_o = done_o && (hec_o == exp_hec_i);
    end
endmodule

// File: rtl/hec_sva_chk.sv
// Property checker for cell_hdr_hec, attached by bind below.
module hec_sva_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       byte_vld_i,
    input logic       word_vld_i,
    input logic [7:0] exp_hec_i,
    input logic [7:0] hec_o,
    input logic       done_o,
    input logic       match_o
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> !done_o);

    assert_done_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(byte_vld_i || word_vld_i));

    assert_hold_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i && !word_vld_i) |=> (done_o && $stable(hec_o)));

    assert_word_completes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_i |=> done_o);

    assert_match_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> !match_o);

    assert_match_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (hec_o == exp_hec_i));

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !byte_vld_i && !word_vld_i) |=> !done_o);
endmodule

bind cell_hdr_hec hec_sva_chk u_hec_sva_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .byte_vld_i (byte_vld_i),
    .word_vld_i (word_vld_i),
    .exp_hec_i  (exp_hec_i),
    .hec_o      (hec_o),
    .done_o     (done_o),
    .match_o    (match_o)
);

// File: tb/cell_hdr_hec_bench.sv
module cell_hdr_hec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, byte_vld_i = 1'b0, word_vld_i = 1'b0;
    logic [7:0]  byte_i = '0, exp_hec_i = '0;
    logic [31:0] word_i = '0;
    logic [7:0]  hec_o;
    logic        done_o, match_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    cell_hdr_hec u_cell_hdr_hec (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .word_vld_i(word_vld_i), .word_i(word_i),
        .exp_hec_i(exp_hec_i), .hec_o(hec_o), .done_o(done_o), .match_o(match_o)
    );

    // Bit-serial reference: header MSB first, feedback 0x07, seed 0, coset 0x55.
    function automatic logic [7:0] ref_hec(input logic [31:0] h);
        logic [7:0] r = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            logic fb = r[7] ^ h[i];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r ^ 8'h55;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Present one byte for one clock (optionally with start).
    task automatic put_byte(input logic [7:0] b, input logic st = 1'b0);
        start_i = st; byte_vld_i = 1'b1; byte_i = b;
        @(negedge clk);
        start_i = 1'b0; byte_vld_i = 1'b0;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic put_word(input logic [31:0] w);
        word_vld_i = 1'b1; word_i = w;
        @(negedge clk);
        word_vld_i = 1'b0;
    endtask

    task automatic send_hdr(input logic [31:0] h);
        pulse_start();
        for (int k = 3; k >= 0; k--) put_byte(h[k*8 +: 8]);
    endtask

    task automatic t_reset();
        check("R1 done after reset", done_o, 1'b0);
        check("R1 match after reset", match_o, 1'b0);
    endtask

    task automatic t_zero();
        pulse_start();
        put_byte(8'h00); put_byte(8'h00); put_byte(8'h00);
        check("R4 done low after three bytes", done_o, 1'b0);
        put_byte(8'h00);
        check("R4 done after fourth byte", done_o, 1'b1);
        check("R2 zero header byte mode", hec_o, 8'h55);
    endtask

    task automatic t_known();
        send_hdr(32'h0000_0001);
        check("R3 header 00000001", hec_o, 8'h52);
        exp_hec_i = 8'h52; #1;
        check("R9 match on equal", match_o, 1'b1);
        exp_hec_i = 8'h53; #1;
        check("R9 no match on differ", match_o, 1'b0);
        for (int i = 0; i < 6; i++) begin
            logic [31:0] h = 32'h9E37_79B9 * (i + 3) ^ (32'h1 << (i * 5));
            send_hdr(h);
            check("R3 assorted header", hec_o, ref_hec(h));
        end
    endtask

    task automatic t_gaps();
        pulse_start();
        put_byte(8'hA5); repeat (3) @(negedge clk);
        put_byte(8'h3C); @(negedge clk);
        put_byte(8'h0F); repeat (2) @(negedge clk);
        check("R5 not done during gaps", done_o, 1'b0);
        put_byte(8'h81);
        check("R5 gapped header", hec_o, ref_hec(32'hA53C_0F81));
    endtask

    task automatic t_extra();
        logic [7:0] held;
        send_hdr(32'hDEAD_BEEF);
        held = hec_o;
        put_byte(8'h77); put_byte(8'h11);
        check("R7 hec unchanged by surplus bytes", hec_o, held);
        check("R7 done held", done_o, 1'b1);
        check("R7 value", held, ref_hec(32'hDEAD_BEEF));
    endtask

    task automatic t_restart();
        pulse_start();
        put_byte(8'hFF); put_byte(8'hEE);
        put_byte(8'h12, 1'b1);              // restart carrying first byte
        put_byte(8'h34); put_byte(8'h56);
        check("R6 not done after three new bytes", done_o, 1'b0);
        put_byte(8'h78);
        check("R6 restarted header", hec_o, ref_hec(32'h1234_5678));
        exp_hec_i = hec_o;
        pulse_start();
        check("R10 start clears done", done_o, 1'b0);
        #1;
        check("R9 match low while not done", match_o, 1'b0);
    endtask

    task automatic t_word();
        put_word(32'h0);
        check("R8 word done next cycle", done_o, 1'b1);
        check("R2 zero header word mode", hec_o, 8'h55);
        put_word(32'h1234_5678);
        check("R8 word equals byte path", hec_o, ref_hec(32'h1234_5678));
        pulse_start();
        put_byte(8'hAB); put_byte(8'hCD);
        put_word(32'h0000_0001);
        check("R8 word replaces partial header", hec_o, 8'h52);
        check("R8 done after word", done_o, 1'b1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_known();
        t_gaps();
        t_extra();
        t_restart();
        t_word();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule